// File: doc/BRIEF.md
# Polarity-Selectable Edge Event Interrupt Detector

This block watches eight already-filtered input bits of one I/O port and records transitions on them. Each channel senses one direction only. A channel whose polarity bit is 1 reacts to a low-to-high transition, and a channel whose polarity bit is 0 reacts to a high-to-low transition. To detect any change on a signal, the signal is wired to two channels set to opposite polarities. The usual wiring sets channels 0 to 3 to rising and channels 4 to 7 to falling, and ties channel n to channel n+4.

Each detected transition sets a sticky status flag for its channel. Software clears a flag by writing a 1 to its position. A single interrupt request is asserted while any flag whose channel is enabled remains set. Debouncing and bus address decode happen outside the block. The block sees them only as the filtered inputs and as a clear strobe with its data.

A two-state sequencer controls edge sensing. After reset it is in `ST_PRIME`. In that cycle the previous-sample register loads the live inputs and edge detection is masked. On the next clock the sequencer takes the `arm` transition to `ST_WATCH`, and it stays there until the next reset.

Top module: `evt_irq_detector`

## Requirements
- R1: While reset is asserted, and directly after it, `evt_flags_o` is all zeros and `irq_o` is 0.
- R2: The first clock edge after reset release (state `ST_PRIME`) sets no flag, whatever the inputs are. That edge captures the inputs as the previous sample, and the sequencer then moves to `ST_WATCH`.
- R3: A channel with `rise_sel_i[n]`=1 sets `evt_flags_o[n]` on the clock edge where `pin_i[n]` is 1 and the previous sample was 0. A high-to-low change on that channel sets nothing.
- R4: A channel with `rise_sel_i[n]`=0 sets `evt_flags_o[n]` on the clock edge where `pin_i[n]` is 0 and the previous sample was 1. A low-to-high change on that channel sets nothing.
- R5: A set flag stays set when the input changes back, and it clears only through a clear write.
- R6: With `clr_wr_i`=1 on a clock edge, each flag whose bit in `clr_data_i` is 1 clears. Flags whose bit is 0 keep their value. While `clr_wr_i`=0, `clr_data_i` has no effect.
- R7: If a channel detects an event on the same edge that a clear write targets it, the event wins and the flag stays 1.
- R8: `irq_o` is 1 exactly when some n has both `evt_flags_o[n]` and `chan_en_i[n]` equal to 1. A flag on a disabled channel still sets, but it does not raise `irq_o`.
- R9: With channel n on rising polarity, channel n+4 on falling polarity, and both tied to one signal, a rise on the signal sets flag n and a fall on the signal sets flag n+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Filtered input bits, one per channel |
| rise_sel_i | input | 8 | Polarity per channel: 1 senses rising, 0 senses falling |
| chan_en_i | input | 8 | Interrupt enable per channel |
| clr_wr_i | input | 1 | Clear write strobe for the status flags |
| clr_data_i | input | 8 | Write-one-to-clear mask, used when `clr_wr_i` is 1 |
| evt_flags_o | output | 8 | Sticky event status flags |
| irq_o | output | 1 | Interrupt request |

## Verification
A change on an input that is applied between clock edges appears in `evt_flags_o` right after the next rising edge, because only the flag register lies on that path. A clear write follows the same one-edge timing. `irq_o` follows the flags and `chan_en_i` within the same cycle, with no added register. The bench applies every stimulus at a falling edge and steps to the following rising edge. It samples 1 ns later and compares against its own model at that point, so each result is read in the cycle it falls due. Checks after an enable change are made without waiting for a clock edge.

// File: rtl/evt_pkg.sv
package evt_pkg;
    typedef enum logic [0:0] {
        ST_PRIME = 1'b0,
        ST_WATCH = 1'b1
    } det_state_e;
endpackage

// File: rtl/evt_seq.sv
module evt_seq
    import evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic arm_o
);
    det_state_e state_q;
    det_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_WATCH;   // arm
            ST_WATCH: state_d = ST_WATCH;
            default:  state_d = ST_PRIME;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    always_comb begin
        arm_o = 1'b0;
        unique case (state_q)
            ST_PRIME: arm_o = 1'b0;
            ST_WATCH: arm_o = 1'b1;
            default:  arm_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/evt_edge_sense.sv
module evt_edge_sense #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           arm_i,
    input  logic [NCH-1:0] pin_i,
    input  logic [NCH-1:0] rise_sel_i,
    output logic [NCH-1:0] hit_o
);
    logic [NCH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_i;
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        logic up_w;
        logic down_w;
        assign up_w     = pin_i[n] & ~prev_q[n];
        assign down_w   = ~pin_i[n] & prev_q[n];
        assign hit_o[n] = arm_i & (rise_sel_i[n] ? up_w : down_w);
    end
endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit_i,
    input  logic           clr_wr_i,
    input  logic [NCH-1:0] clr_data_i,
    output logic [NCH-1:0] flags_o
);
    logic [NCH-1:0] wipe_w;
    logic [NCH-1:0] flags_d;

    assign wipe_w  = clr_wr_i ? clr_data_i : '0;
    assign flags_d = (flags_o & ~wipe_w) | hit_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= flags_d;
    end
endmodule

// File: rtl/evt_irq_merge.sv
module evt_irq_merge #(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0] flags_i,
    input  logic [NCH-1:0] en_i,
    output logic           irq_o
);
    assign irq_o = |(flags_i & en_i);
endmodule

// File: rtl/evt_irq_detector.sv
module evt_irq_detector #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin_i,
    input  logic [NCH-1:0] rise_sel_i,
    input  logic [NCH-1:0] chan_en_i,
    input  logic           clr_wr_i,
    input  logic [NCH-1:0] clr_data_i,
    output logic [NCH-1:0] evt_flags_o,
    output logic           irq_o
);
    logic           arm_w;
    logic [NCH-1:0] hit_w;

    evt_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .arm_o (arm_w)
    );

    evt_edge_sense #(.NCH(NCH)) u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm_w),
        .pin_i      (pin_i),
        .rise_sel_i (rise_sel_i),
        .hit_o      (hit_w)
    );

    evt_flag_bank #(.NCH(NCH)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit_w),
        .clr_wr_i   (clr_wr_i),
        .clr_data_i (clr_data_i),
        .flags_o    (evt_flags_o)
    );

    evt_irq_merge #(.NCH(NCH)) u_irq (
        .flags_i (evt_flags_o),
        .en_i    (chan_en_i),
        .irq_o   (irq_o)
    );
endmodule

// File: rtl/evt_irq_detector_chk.sv
module evt_irq_detector_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] pin_i,
    input logic [NCH-1:0] rise_sel_i,
    input logic [NCH-1:0] chan_en_i,
    input logic           clr_wr_i,
    input logic [NCH-1:0] clr_data_i,
    input logic [NCH-1:0] evt_flags_o,
    input logic           irq_o
);
    logic [1:0]     since_rst;
    logic [NCH-1:0] last_pin;
    logic [NCH-1:0] seen_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
            last_pin  <= '0;
        end else begin
            if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
            last_pin <= pin_i;
        end
    end

    always_comb begin
        seen_edge = '0;
        if (since_rst != 2'd0)
            seen_edge = (rise_sel_i & pin_i & ~last_pin) |
                        (~rise_sel_i & ~pin_i & last_pin);
    end

    // R2
    prime_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd1) |-> (evt_flags_o == '0));

    // R3
    flag_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0) |=> ((evt_flags_o & ~$past(evt_flags_o) & ~$past(seen_edge)) == '0));

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr_i |=> ((evt_flags_o & $past(evt_flags_o)) == $past(evt_flags_o)));

    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr_i |=> ((evt_flags_o & $past(clr_data_i) & ~$past(seen_edge)) == '0));

    // R8
    irq_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> ($past(clr_wr_i) || (chan_en_i != $past(chan_en_i))));
endmodule

bind evt_irq_detector evt_irq_detector_chk #(.NCH(NCH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin_i),
    .rise_sel_i  (rise_sel_i),
    .chan_en_i   (chan_en_i),
    .clr_wr_i    (clr_wr_i),
    .clr_data_i  (clr_data_i),
    .evt_flags_o (evt_flags_o),
    .irq_o       (irq_o)
);

// File: tb/evt_irq_detector_tb_top.sv
`timescale 1ns/1ps
module evt_irq_detector_tb_top;
    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pin_i = '1;
    logic [NCH-1:0] rise_sel_i = 8'h0F;
    logic [NCH-1:0] chan_en_i = '1;
    logic           clr_wr_i = 1'b0;
    logic [NCH-1:0] clr_data_i = '0;
    logic [NCH-1:0] evt_flags_o;
    logic           irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [NCH-1:0] m_flags = '0;
    logic [NCH-1:0] m_prev = '0;
    bit             m_armed = 1'b0;

    always #2 clk = ~clk;

    evt_irq_detector #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rise_sel_i(rise_sel_i),
        .chan_en_i(chan_en_i), .clr_wr_i(clr_wr_i), .clr_data_i(clr_data_i),
        .evt_flags_o(evt_flags_o), .irq_o(irq_o)
    );

    function automatic logic [NCH-1:0] next_flags(logic [NCH-1:0] f, logic [NCH-1:0] p,
                                                  logic [NCH-1:0] pv, logic [NCH-1:0] rs,
                                                  logic wr, logic [NCH-1:0] d, bit armed);
        logic [NCH-1:0] hit;
        hit = armed ? ((rs & p & ~pv) | (~rs & ~p & pv)) : '0;
        return (f & ~(wr ? d : '0)) | hit;
    endfunction

    function automatic logic exp_irq(logic [NCH-1:0] f, logic [NCH-1:0] e);
        return |(f & e);
    endfunction

    task automatic chk_flags(string req, logic [NCH-1:0] exp);
        checks++;
        if (evt_flags_o !== exp) begin
            errors++;
            $display("FAIL %s flags actual=%h expected=%h", req, evt_flags_o, exp);
        end
    endtask

    task automatic chk_irq(string req, logic exp);
        checks++;
        if (irq_o !== exp) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", req, irq_o, exp);
        end
    endtask

    task automatic tick(logic [NCH-1:0] p, logic wr, logic [NCH-1:0] d);
        @(negedge clk);
        pin_i = p; clr_wr_i = wr; clr_data_i = d;
        @(posedge clk);
        m_flags = next_flags(m_flags, pin_i, m_prev, rise_sel_i, clr_wr_i, clr_data_i, m_armed);
        m_prev  = pin_i;
        m_armed = 1'b1;
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'h1F2E);
        repeat (3) @(posedge clk);
        #1;
        chk_flags("R1", 8'h00);
        chk_irq("R1", 1'b0);

        @(negedge clk);
        rst_n = 1'b1;
        // first edge after release is the priming edge: inputs FF, previous 00
        tick(8'hFF, 1'b0, '0);
        chk_flags("R2", 8'h00);
        chk_irq("R2", 1'b0);

        // signal 0 falls: channel 4 (falling) flags, channel 0 (rising) does not
        tick(8'hEE, 1'b0, '0);
        chk_flags("R4 R9", 8'h10);
        chk_irq("R8", 1'b1);
        // signal 0 rises: channel 0 flags, channel 4 stays set
        tick(8'hFF, 1'b0, '0);
        chk_flags("R3 R5 R9", 8'h11);
        // data without strobe has no effect
        tick(8'hFF, 1'b0, 8'hFF);
        chk_flags("R6", 8'h11);
        // clear channel 0 only
        tick(8'hFF, 1'b1, 8'h01);
        chk_flags("R6", 8'h10);
        // clear channel 4 while it sees a new fall: event wins
        tick(8'hEE, 1'b1, 8'h10);
        chk_flags("R7", 8'h10);
        // disabled channel keeps flag but no interrupt
        @(negedge clk);
        chan_en_i = 8'hEF;
        #1;
        chk_irq("R8", 1'b0);
        chk_flags("R8", 8'h10);
        chan_en_i = 8'hFF;
        #1;
        chk_irq("R8", 1'b1);
        // rise on channel 4 (falling polarity) sets nothing new; clear all
        tick(8'hFF, 1'b1, 8'hFF);
        chk_flags("R4 R6", 8'h01);
        tick(8'hFF, 1'b1, 8'hFF);
        chk_flags("R6", 8'h00);
        chk_irq("R8", 1'b0);
        m_flags = evt_flags_o;

        // constrained random phase
        rise_sel_i = 8'($urandom);
        for (int k = 0; k < 400; k++) begin
            logic [NCH-1:0] p;
            logic           wr;
            logic [NCH-1:0] d;
            p  = ($urandom % 3 == 0) ? 8'($urandom) : pin_i;
            wr = ($urandom % 4 == 0);
            d  = 8'($urandom);
            if (k % 50 == 0) chan_en_i = 8'($urandom);
            tick(p, wr, d);
            chk_flags("R3 R4 R5 R6 R7", m_flags);
            chk_irq("R8", exp_irq(m_flags, chan_en_i));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule